// File: doc/BRIEF.md
# Command Packet Stream Framer

The framer sits on a stream of 32-bit command words that arrive over a valid/ready handshake and cuts that stream into packets. The first word of each packet is a header. The header gives a 2-bit packet kind in its top two bits and a 14-bit count field in bits 29:16. The count plus one is the number of body words that follow. The header itself is consumed and never forwarded. Each body word then goes downstream unchanged, together with the fields decoded from its header and markers for the first and last word of the packet.

Kind-0 packets carry a register base index in header bits 15:0. Each of their body words also carries a register address equal to that base plus the word's position. Kind-3 packets carry an opcode in header bits 15:8 and two flag bits in bits 1:0. A kind-3 packet with the no-operation opcode has its body swallowed without being forwarded. A header of kind 1 or 2 sets a sticky error flag, and the next word is taken as a fresh header. A counter records every packet whose last body word has been consumed.

Body words pass through without buffering: the input is held off whenever downstream holds off, so no word is lost or duplicated.

Top module: `cmd_framer`

## Requirements
- R1: After reset, out_valid is 0, bad_kind is 0, pkt_count is 0, and in_ready is 1, because the block is waiting for a header.
- R2: A header's kind is taken from bits 31:30 and its count field from bits 29:16. Exactly count+1 body words follow the header. The header is never presented on the output. The word after the last body word is treated as a header.
- R3: For a kind-3 packet, every forwarded body word shows out_kind=3, out_opcode=header bits 15:8, out_pred=header bit 0, out_shader=header bit 1 and out_base=0. A header built as 0xC0000000 | count<<16 | opcode<<8 | flags is parsed this way.
- R4: For a kind-0 packet, every body word shows out_kind=0, out_opcode=0, out_pred=0, out_shader=0 and out_base=header bits 15:0. Its out_reg_addr is out_base plus the word's zero-based position k, modulo 2^16. For kind-3 packets, out_reg_addr is k.
- R5: out_first is 1 exactly on body word k=0, and out_last is 1 exactly on body word k=count, of every forwarded packet.
- R6: For a kind-3 packet with opcode 0x10 (NOP_OPCODE), all count+1 body words are accepted with in_ready=1 regardless of out_ready, and out_valid stays 0 throughout.
- R7: A header of kind 1 or 2 is consumed, sets bad_kind to 1, and produces no output. The next word is decoded as a header. bad_kind stays 1 until reset.
- R8: While a body word is offered downstream and out_ready is 0, in_ready is 0. Every body word reaches the output exactly once and in order. out_valid is never 1 without in_valid.
- R9: pkt_count increments by exactly one in the cycle in which the last body word of a kind-0 or kind-3 packet is accepted, whether that packet is forwarded or swallowed. It wraps at 2^PKT_CNT_W and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Incoming command word |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Block takes the word this cycle |
| out_data | output | 32 | Forwarded body word |
| out_valid | output | 1 | A body word is offered |
| out_ready | input | 1 | Downstream takes the word |
| out_kind | output | 2 | Packet kind from the header |
| out_opcode | output | 8 | Kind-3 opcode, 0 for kind 0 |
| out_base | output | 16 | Kind-0 register base, 0 for kind 3 |
| out_reg_addr | output | 16 | Base plus word position |
| out_pred | output | 1 | Kind-3 predicate flag |
| out_shader | output | 1 | Kind-3 shader-type flag |
| out_first | output | 1 | First body word of the packet |
| out_last | output | 1 | Last body word of the packet |
| bad_kind | output | 1 | Sticky flag for a kind-1 or kind-2 header |
| pkt_count | output | PKT_CNT_W | Packets consumed |

## Verification
The two functions that meet in one cycle are backpressure and packet completion. A stall can fall on the last body word, so that the counter increment and the return to header decoding must wait for the handshake. The bench provokes this by throttling out_ready on a fixed pattern while packets of several lengths stream through. One of these packets has a single body word, where first and last coincide. The scoreboard judges every delivered word's fields and markers, and each stalled cycle is checked for a low in_ready. The final packet count and an empty expectation queue show that no word was lost and no packet completed twice.

// File: rtl/cmd_framer.sv
module cmd_framer #(
  parameter int unsigned PKT_CNT_W = 16,
  parameter logic [7:0]  NOP_OPCODE = 8'h10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [31:0]          out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_kind,
  output logic [7:0]           out_opcode,
  output logic [15:0]          out_base,
  output logic [15:0]          out_reg_addr,
  output logic                 out_pred,
  output logic                 out_shader,
  output logic                 out_first,
  output logic                 out_last,
  output logic                 bad_kind,
  output logic [PKT_CNT_W-1:0] pkt_count
);
  localparam int unsigned LEN_W = 14;
  localparam int unsigned ADDR_W = 16;

  logic              in_body, drop_q, pred_q, shader_q;
  logic [LEN_W-1:0]  left_q, pos_q;
  logic [1:0]        kind_q;
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] base_q;

  wire [1:0] hdr_kind = in_data[31:30];
  wire       hdr_ok   = (hdr_kind == 2'd0) || (hdr_kind == 2'd3);
  wire       hdr_t3   = (hdr_kind == 2'd3);
  wire       accept   = in_valid && in_ready;
  wire       at_end   = (left_q == '0);

  assign in_ready     = !in_body || drop_q || out_ready;
  assign out_valid    = in_body && !drop_q && in_valid;
  assign out_data     = in_data;
  assign out_kind     = kind_q;
  assign out_opcode   = op_q;
  assign out_base     = base_q;
  assign out_reg_addr = base_q + ADDR_W'(pos_q);
  assign out_pred     = pred_q;
  assign out_shader   = shader_q;
  assign out_first    = (pos_q == '0);
  assign out_last     = at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_body   <= 1'b0;
      drop_q    <= 1'b0;
      pred_q    <= 1'b0;
      shader_q  <= 1'b0;
      left_q    <= '0;
      pos_q     <= '0;
      kind_q    <= '0;
      op_q      <= '0;
      base_q    <= '0;
      bad_kind  <= 1'b0;
      pkt_count <= '0;
    end else if (accept) begin
      if (!in_body) begin
        if (hdr_ok) begin
          in_body  <= 1'b1;
          left_q   <= in_data[29:16];
          pos_q    <= '0;
          kind_q   <= hdr_kind;
          op_q     <= hdr_t3 ? in_data[15:8] : 8'h00;
          base_q   <= hdr_t3 ? '0 : in_data[15:0];
          pred_q   <= hdr_t3 & in_data[0];
          shader_q <= hdr_t3 & in_data[1];
          drop_q   <= hdr_t3 && (in_data[15:8] == NOP_OPCODE);
        end else begin
          bad_kind <= 1'b1;
        end
      end else begin
        pos_q  <= pos_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (at_end) begin
          in_body   <= 1'b0;
          drop_q    <= 1'b0;
          pkt_count <= pkt_count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_framer_sva.sv
module cmd_framer_sva #(
  parameter int unsigned PKT_CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [1:0]           out_kind,
  input logic [15:0]          out_reg_addr,
  input logic                 out_first,
  input logic                 out_last,
  input logic                 bad_kind,
  input logic [PKT_CNT_W-1:0] pkt_count
);
  AST_STALL_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_NO_OUTPUT_WITHOUT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid); // R8

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind == 2'd0 || out_kind == 2'd3)); // R2

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> (out_valid |-> !out_first)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=>
      (out_valid |-> out_reg_addr == $past(out_reg_addr) + 16'd1)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kind |=> bad_kind); // R7

  AST_COUNT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> pkt_count == $past(pkt_count) + 1'b1); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pkt_count == $past(pkt_count) || pkt_count == $past(pkt_count) + 1'b1)); // R9
endmodule

bind cmd_framer cmd_framer_sva #(.PKT_CNT_W(PKT_CNT_W)) u_cmd_framer_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_reg_addr(out_reg_addr), .out_first(out_first), .out_last(out_last),
  .bad_kind(bad_kind), .pkt_count(pkt_count)
);

// File: tb/cmd_framer_bench.sv
module cmd_framer_bench;
  localparam int CW = 16;
  localparam logic [7:0] NOP = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] out_data;
  logic [1:0] out_kind;
  logic [7:0] out_opcode;
  logic [15:0] out_base, out_reg_addr;
  logic out_pred, out_shader, out_first, out_last, bad_kind;
  logic [CW-1:0] pkt_count;

  cmd_framer #(.PKT_CNT_W(CW), .NOP_OPCODE(NOP)) u_cmd_framer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_opcode(out_opcode), .out_base(out_base), .out_reg_addr(out_reg_addr),
    .out_pred(out_pred), .out_shader(out_shader), .out_first(out_first), .out_last(out_last),
    .bad_kind(bad_kind), .pkt_count(pkt_count));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] data; logic [1:0] kind; logic [7:0] op; logic [15:0] base;
    logic [15:0] addr; logic pred; logic sh; logic first; logic last;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0, exp_pkts = 0, bp_mode = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready <= (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // monitor
  initial forever begin
    @(negedge clk); #9;
    if (rst_n && out_valid && !out_ready)
      check(!in_ready, "R8 stall", {79'd0, in_ready}, 80'd0);
    if (rst_n && out_valid && out_ready) begin
      item_t got;
      got = '{out_data, out_kind, out_opcode, out_base, out_reg_addr,
              out_pred, out_shader, out_first, out_last};
      if (exp_q.size() == 0) check(1'b0, "R2 R6 unexpected output", got, 80'd0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        check(got == e, "R2 R3 R4 R5 word", got, e);
      end
    end
  end

  task automatic push_word(input logic [31:0] w);
    bit ok;
    @(negedge clk); in_valid = 1'b1; in_data = w;
    forever begin
      #9; ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0; in_data = 32'hDEAD_BEEF;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_t3(input logic [7:0] op, input logic [13:0] cnt, input logic p, input logic s, input logic [31:0] seed);
    for (int k = 0; k <= cnt; k++)
      if (op != NOP)
        exp_q.push_back('{seed + k * 7, 2'd3, op, 16'd0, 16'(k), p, s, k == 0, k == cnt});
    exp_pkts++;
    push_word(32'hC000_0000 | (32'(cnt) << 16) | (32'(op) << 8) | {30'd0, s, p});
    for (int k = 0; k <= cnt; k++) push_word(seed + k * 7);
    idle(2);
  endtask

  task automatic send_t0(input logic [15:0] base, input logic [13:0] cnt, input logic [31:0] seed);
    for (int k = 0; k <= cnt; k++)
      exp_q.push_back('{seed + k * 5, 2'd0, 8'd0, base, base + 16'(k), 1'b0, 1'b0, k == 0, k == cnt});
    exp_pkts++;
    push_word({2'b00, cnt, base});
    for (int k = 0; k <= cnt; k++) push_word(seed + k * 5);
    idle(2);
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(out_valid == 0, "R1 out_valid", {79'd0, out_valid}, 80'd0);
    check(bad_kind == 0, "R1 bad_kind", {79'd0, bad_kind}, 80'd0);
    check(pkt_count == 0, "R1 pkt_count", 80'(pkt_count), 80'd0);
    check(in_ready == 1, "R1 in_ready", {79'd0, in_ready}, 80'd1);

    bp_mode = 0;
    send_t3(8'h37, 14'd2, 1'b1, 1'b0, 32'h1000_0000);
    send_t0(16'h0100, 14'd0, 32'h2000_0000);
    send_t3(NOP, 14'd3, 1'b0, 1'b0, 32'h3000_0000); // R6
    drain();
    check(exp_q.size() == 0, "R6 nop swallowed", 80'(exp_q.size()), 80'd0);
    check(pkt_count == 16'(exp_pkts), "R9 count after nop", 80'(pkt_count), 80'(exp_pkts));
    send_t3(8'h69, 14'd1, 1'b0, 1'b1, 32'h4000_0000);

    bp_mode = 1;
    send_t0(16'hFFFE, 14'd4, 32'h5000_0000); // R4 wrap
    send_t3(8'h46, 14'd5, 1'b1, 1'b1, 32'h6000_0000);
    send_t3(NOP, 14'd2, 1'b1, 1'b0, 32'h6100_0000); // R6 under stall
    send_t0(16'h0020, 14'd0, 32'h6200_0000);
    drain();
    check(bad_kind == 0, "R7 no error yet", {79'd0, bad_kind}, 80'd0);

    // R7 kind 1 then kind 2 headers, each followed by a good packet
    push_word(32'h4003_1234);
    send_t3(8'h2D, 14'd0, 1'b0, 1'b0, 32'h7000_0000);
    drain();
    check(bad_kind == 1, "R7 kind1 sets flag", {79'd0, bad_kind}, 80'd1);
    push_word(32'h8001_00AA);
    send_t0(16'h0300, 14'd2, 32'h8000_0000);
    drain();
    check(bad_kind == 1, "R7 flag sticky", {79'd0, bad_kind}, 80'd1);

    bp_mode = 0;
    send_t3(8'h76, 14'd40, 1'b0, 1'b1, 32'h9000_0000);
    drain();
    check(exp_q.size() == 0, "R2 R8 all words delivered", 80'(exp_q.size()), 80'd0);
    check(pkt_count == 16'(exp_pkts), "R9 final count", 80'(pkt_count), 80'(exp_pkts));
    finish_run();
  end
endmodule